// File: doc/BRIEF.md
# AES-128 Round-Key Expander and Bank

This block turns a 128-bit cipher key into the eleven 128-bit round keys of AES-128. A load strobe captures the cipher key, which becomes round key 0. On each following clock edge one further round key is derived from the one before it and written into an eleven-entry bank. After the tenth such edge the whole schedule is present and a ready flag goes high.

A round sequencer picks a key by giving a round number and a direction. In the forward direction the number addresses the bank as it is. In the reverse direction the block maps the number so that round 0 receives the last key, which is what decryption needs. Since key k is written k edges after the load edge, an encryption sequencer can stay one step behind the generator. A decryption sequencer waits for the ready flag.

Top module: `aes128_key_bank`

## Requirements
- R1: After reset, `keys_ready` is 0 and `round_key` is all zeros for every valid round number.
- R2: When `key_load` is high at a clock edge, `key_in` is stored as round key 0. It can be read in the cycle after that edge. Byte 0 of the key is bits 127:120, and word 0 is bits 127:96.
- R3: Round key k (1..10) is derived from key k-1 as follows. New word 0 = old word 0 XOR SubWord(RotWord(old word 3)) XOR {rc, 24'h0}. RotWord moves the top byte of a word to the bottom. The rc values for k = 1..10 are 01,02,04,08,10,20,40,80,1B,36. Each new word 1..3 = old word of the same position XOR the new word before it.
- R4: Exactly one key is produced per clock. Key k can be read after the k-th edge that follows the load edge.
- R5: `keys_ready` rises in the cycle after the tenth edge that follows the load edge. It then stays high until the next load.
- R6: A load, including one made while generation is still running, clears `keys_ready` in the next cycle and restarts generation from the new key.
- R7: With `decrypt`=0, `round_key` is bank entry `rd_round`. With `decrypt`=1, it is bank entry 10 − `rd_round`.
- R8: A `rd_round` value above 10 gives an all-zero `round_key` in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_load | input | 1 | Captures `key_in` and starts expansion |
| key_in | input | 128 | Cipher key |
| decrypt | input | 1 | 1 selects keys in reverse order |
| rd_round | input | 4 | Round number from the sequencer |
| round_key | output | 128 | Selected round key |
| keys_ready | output | 1 | All eleven keys are stored |

## Verification
The block has no tunable parameters: the key width, word count and bank depth are fixed by AES-128. The bench therefore builds its only configuration. Because of this, every round and every Rcon step can be reached in each run. The bench covers the published reference key, a run of seeded random keys, and all-zero and all-ones keys. It also reloads a key partway through expansion and reads every entry in both directions, including out-of-range round numbers.

// File: rtl/aes128_key_bank.sv
module aes128_key_bank (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_load,
  input  logic [127:0] key_in,
  input  logic         decrypt,
  input  logic [3:0]   rd_round,
  output logic [127:0] round_key,
  output logic         keys_ready
);
  localparam int NKEYS = 11;
  localparam logic [3:0] LAST = 4'(NKEYS - 1);

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa;
    p = '0; aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xt(aa);
    end
    return p;
  endfunction

  function automatic logic [7:0] sb(input logic [7:0] x);
    logic [7:0] sq, inv, y;
    sq = gm(x, x);
    inv = sq;
    for (int i = 0; i < 6; i++) begin
      sq = gm(sq, sq);
      inv = gm(inv, sq);
    end
    for (int i = 0; i < 8; i++)
      y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return y ^ 8'h63;
  endfunction

  logic [127:0] bank [NKEYS];
  logic [127:0] cur, nxt;
  logic [3:0]   cnt;
  logic [7:0]   rcon;
  logic         busy;

  logic [31:0] w0, w1, w2, w3, t;
  assign t  = {sb(cur[23:16]), sb(cur[15:8]), sb(cur[7:0]), sb(cur[31:24])} ^ {rcon, 24'h0};
  assign w0 = cur[127:96] ^ t;
  assign w1 = cur[95:64] ^ w0;
  assign w2 = cur[63:32] ^ w1;
  assign w3 = cur[31:0]  ^ w2;
  assign nxt = {w0, w1, w2, w3};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NKEYS; i++) bank[i] <= '0;
      cur <= '0;
      cnt <= '0;
      rcon <= '0;
      busy <= 1'b0;
      keys_ready <= 1'b0;
    end else if (key_load) begin
      bank[0] <= key_in;
      cur <= key_in;
      cnt <= 4'd1;
      rcon <= 8'h01;
      busy <= 1'b1;
      keys_ready <= 1'b0;
    end else if (busy) begin
      for (int i = 1; i < NKEYS; i++)
        if (cnt == 4'(i)) bank[i] <= nxt;
      cur <= nxt;
      rcon <= xt(rcon);
      if (cnt == LAST) begin
        busy <= 1'b0;
        keys_ready <= 1'b1;
      end else begin
        cnt <= cnt + 4'd1;
      end
    end
  end

  logic [3:0] sel;
  assign sel = decrypt ? LAST - rd_round : rd_round;

  always_comb begin
    round_key = '0;
    if (rd_round <= LAST)
      for (int i = 0; i < NKEYS; i++)
        if (sel == 4'(i)) round_key = bank[i];
  end

  p_load_clears_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> !keys_ready);
  p_key0_captured_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> bank[0] == $past(key_in));
  p_ready_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    keys_ready && !key_load |=> keys_ready);
  p_ready_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(keys_ready) |-> $past(busy) && $past(cnt) == LAST);
  p_ready_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    keys_ready |-> !busy);
  p_out_of_range_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_round > LAST |-> round_key == '0);
endmodule

// File: tb/tb_aes128_key_bank.sv
module tb_aes128_key_bank;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0, key_load = 0, decrypt = 0;
  logic [127:0] key_in = '0;
  logic [3:0] rd_round = '0;
  logic [127:0] round_key;
  logic keys_ready;
  int total = 0, bad = 0;

  aes128_key_bank dut (.clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .decrypt(decrypt), .rd_round(rd_round), .round_key(round_key), .keys_ready(keys_ready));

  always #(PERIOD/2) clk = ~clk;

  logic [7:0] sbox [256];
  logic [127:0] exp_keys [11];

  function automatic logic [7:0] mul3(input logic [7:0] a);
    return a ^ ({a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00));
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  task automatic build_sbox();
    logic [7:0] ex [256];
    int lg [256];
    logic [7:0] v = 8'h01;
    for (int i = 0; i < 255; i++) begin ex[i] = v; lg[v] = i; v = mul3(v); end
    for (int x = 0; x < 256; x++) begin
      logic [7:0] b;
      b = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
      sbox[x] = b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 8'h63;
    end
  endtask

  task automatic expand(input logic [127:0] k);
    logic [31:0] w [44];
    logic [7:0] rc [10] = '{8'h01,8'h02,8'h04,8'h08,8'h10,8'h20,8'h40,8'h80,8'h1b,8'h36};
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] tmp;
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {tmp[23:0], tmp[31:24]};
        tmp = {sbox[tmp[31:24]], sbox[tmp[23:16]], sbox[tmp[15:8]], sbox[tmp[7:0]]};
        tmp[31:24] = tmp[31:24] ^ rc[i/4 - 1];
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int r = 0; r < 11; r++) exp_keys[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_key(input logic dir, input int r, output logic [127:0] v);
    decrypt = dir; rd_round = 4'(r); #1; v = round_key;
  endtask

  // Load, then follow generation cycle by cycle (R2 R4 R5 R6 R3)
  task automatic load_and_follow(input logic [127:0] k);
    logic [127:0] v;
    expand(k);
    @(negedge clk); key_load = 1; key_in = k;
    @(negedge clk); key_load = 0;
    read_key(0, 0, v); check("R2", v, exp_keys[0]);
    check("R6", {127'd0, keys_ready}, 128'd0);
    for (int kk = 1; kk <= 10; kk++) begin
      @(negedge clk);
      read_key(0, kk, v); check("R4/R3", v, exp_keys[kk]);
      check("R5", {127'd0, keys_ready}, {127'd0, kk == 10});
    end
  endtask

  task automatic sweep_all();
    logic [127:0] v;
    for (int r = 0; r < 16; r++) begin
      read_key(0, r, v); check(r > 10 ? "R8" : "R7 fwd", v, r > 10 ? 128'd0 : exp_keys[r]);
      read_key(1, r, v); check(r > 10 ? "R8" : "R7 rev", v, r > 10 ? 128'd0 : exp_keys[10-r]);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] v;
    void'($urandom(32'd1234));
    build_sbox();
    #(PERIOD*2 + 1ns);
    // R1 reset state
    check("R1", {127'd0, keys_ready}, 128'd0);
    for (int r = 0; r < 11; r++) begin read_key(r % 2, r, v); check("R1", v, 128'd0); end
    @(negedge clk); rst_n = 1;
    // reference vector
    load_and_follow(128'h2b7e151628aed2a6abf7158809cf4f3c);
    check("R3 ref", exp_keys[10], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    sweep_all();
    // ready holds while idle (R5)
    repeat (5) @(negedge clk);
    #1 check("R5 hold", {127'd0, keys_ready}, 128'd1);
    // corner keys
    load_and_follow('0); sweep_all();
    load_and_follow('1); sweep_all();
    // reload mid generation (R6)
    @(negedge clk); key_load = 1; key_in = {4{$urandom()}};
    @(negedge clk); key_load = 0;
    repeat (4) @(negedge clk);
    load_and_follow({$urandom(), $urandom(), $urandom(), $urandom()});
    sweep_all();
    // random keys
    for (int n = 0; n < 20; n++) begin
      load_and_follow({$urandom(), $urandom(), $urandom(), $urandom()});
      for (int j = 0; j < 4; j++) begin
        int r = $urandom_range(0, 15);
        logic d = 1'($urandom());
        read_key(d, r, v);
        check("R7/R8 rand", v, r > 10 ? 128'd0 : exp_keys[d ? 10 - r : r]);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule